// File: doc/BRIEF.md
# Grouping Command Queue Insertion

This block holds a small, ordered queue of memory commands and decides where each new command goes. Each command carries a direction (read or write), a priority level, a source tag and an address. The queue is not a FIFO. A new command is placed ahead of less urgent entries. It is never placed ahead of an entry from the same source, and never ahead of an entry whose address falls in the same line. When grouping is enabled, the command may also move forward to sit directly behind the last command of its own direction. Grouping this way reduces read/write turnaround on the memory bus.

The slot at the head is exposed to an executor, which removes it with a pop strobe. A push and a pop may happen in the same cycle. The position is computed on the queue as it stood before the pop, and the removal of the head is then applied to that result. Once placed, an entry never changes its position relative to the entries that were already queued. Only later insertions can land in front of it.

Top module: `cq_place_queue`

## Requirements
- R1: After reset the queue is empty: `head_valid` is 0 and `in_ready` is 1.
- R2: A lower priority number is more urgent. Let the barrier be the slot just behind the last entry that blocks the new command under R3 or R4, or slot 0 if no entry blocks it. Without grouping, the new command lands at the first slot at or after the barrier whose entry has a larger priority number than the new command. If there is no such slot, it lands at the tail. Entries of equal priority therefore stay in arrival order.
- R3: A new command is never placed ahead of a queued entry with the same `in_src`.
- R4: A new command is never placed ahead of a queued entry whose address matches its own in every bit set in `cfg_line_mask`.
- R5: Grouping applies when `cfg_group_en`=1 and `in_wbuf_hit`=0. Take the run of entries that ends just before the R2 slot, begins no earlier than the barrier, and whose priority all equals the new command's priority. If that run holds an entry of the same direction (`in_wr`: 0 = read, 1 = write), the new command lands directly behind the last such entry. Otherwise the R2 slot is used.
- R6: With `cfg_group_en`=0, or with `in_wbuf_hit`=1, placement follows R2 alone.
- R7: The head outputs show slot 0. An executed pop removes it and moves every other entry up by one while keeping their order.
- R8: With all DEPTH slots occupied, `in_ready` is 0 and a push is ignored. A pop in that cycle still takes effect.
- R9: A pop while the queue is empty is ignored. A push and a pop in the same cycle leave the occupancy unchanged, and the insertion is computed on the pre-pop queue.

Placement rules R2 to R6 are resolved as a single slot choice. Under grouping, R5 selects that slot from within the R2 bounds, so it never violates R3 or R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_group_en | input | 1 | Enables direction grouping |
| cfg_line_mask | input | ADDR_W | Address bits compared for collision |
| in_valid | input | 1 | New command present |
| in_ready | output | 1 | Queue can accept a command |
| in_wr | input | 1 | Direction: 1 write, 0 read |
| in_prio | input | PRIO_W | Priority, 0 most urgent |
| in_src | input | SRC_W | Source tag |
| in_addr | input | ADDR_W | Command address |
| in_wbuf_hit | input | 1 | Write-buffer conflict; suppresses grouping |
| pop | input | 1 | Executor removes the head |
| head_valid | output | 1 | Queue holds at least one entry |
| head_wr | output | 1 | Direction of head entry |
| head_prio | output | PRIO_W | Priority of head entry |
| head_src | output | SRC_W | Source of head entry |
| head_addr | output | ADDR_W | Address of head entry |

## Verification
Every push or pop is taken at one rising edge. The resulting head fields and `in_ready` are then visible exactly one cycle later, and `in_ready` is also valid combinationally from the stored occupancy. The bench drives each stimulus on a falling edge, lets one rising edge pass, and compares all outputs on the next falling edge against a queue model it updates in step. The placement order itself is only visible at the head. The directed cases therefore drain the queue pop by pop and compare each head against a literal expected sequence.

// File: rtl/cq_pkg.sv
package cq_pkg;
   localparam int CQ_MAX_DEPTH = 64;

   typedef enum logic {
      CQ_READ  = 1'b0,
      CQ_WRITE = 1'b1
   } cq_dir_e;
endpackage

// File: rtl/cq_match.sv
module cq_match #(
   parameter int DEPTH  = 8,
   parameter int PRIO_W = 2,
   parameter int SRC_W  = 3,
   parameter int ADDR_W = 16,
   parameter int ENT_W  = 1 + PRIO_W + SRC_W + ADDR_W
) (
   input  logic [ENT_W-1:0]  slot [DEPTH],
   input  logic              new_wr,
   input  logic [PRIO_W-1:0] new_prio,
   input  logic [SRC_W-1:0]  new_src,
   input  logic [ADDR_W-1:0] new_addr,
   input  logic [ADDR_W-1:0] line_mask,
   output logic [DEPTH-1:0]  blk,
   output logic [DEPTH-1:0]  same_dir,
   output logic [DEPTH-1:0]  less_urgent,
   output logic [DEPTH-1:0]  prio_diff
);
   localparam int SRC_LSB  = ADDR_W;
   localparam int PRIO_LSB = ADDR_W + SRC_W;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [ADDR_W-1:0] s_addr;
      logic [SRC_W-1:0]  s_src;
      logic [PRIO_W-1:0] s_prio;
      cq_pkg::cq_dir_e   s_dir;

      assign s_addr = slot[i][ADDR_W-1:0];
      assign s_src  = slot[i][SRC_LSB +: SRC_W];
      assign s_prio = slot[i][PRIO_LSB +: PRIO_W];
      assign s_dir  = cq_pkg::cq_dir_e'(slot[i][ENT_W-1]);

      assign blk[i]         = (s_src == new_src) ||
                              (((s_addr ^ new_addr) & line_mask) == '0);
      assign same_dir[i]    = (s_dir == cq_pkg::cq_dir_e'(new_wr));
      assign less_urgent[i] = (s_prio > new_prio);
      assign prio_diff[i]   = (s_prio != new_prio);
   end
endmodule

// File: rtl/cq_pick.sv
module cq_pick #(
   parameter int DEPTH    = 8,
   parameter bit GROUPING = 1'b1,
   parameter int CNT_W    = $clog2(DEPTH + 1)
) (
   input  logic [DEPTH-1:0] live,
   input  logic [DEPTH-1:0] blk,
   input  logic [DEPTH-1:0] same_dir,
   input  logic [DEPTH-1:0] less_urgent,
   input  logic [DEPTH-1:0] prio_diff,
   input  logic [CNT_W-1:0] fill,
   input  logic             grp_ok,
   output logic [CNT_W-1:0] pos
);
   int barrier;
   int prio_slot;
   int run_start;
   logic hit;

   always_comb begin
      barrier = 0;
      for (int i = 0; i < DEPTH; i++)
         if (live[i] && blk[i]) barrier = i + 1;

      prio_slot = int'(fill);
      hit       = 1'b0;
      for (int i = 0; i < DEPTH; i++)
         if (!hit && live[i] && i >= barrier && less_urgent[i]) begin
            prio_slot = i;
            hit       = 1'b1;
         end

      run_start = barrier;
      for (int i = 0; i < DEPTH; i++)
         if (i >= barrier && i < prio_slot && prio_diff[i]) run_start = i + 1;
   end

   if (GROUPING) begin : g_group
      int grp_slot;
      always_comb begin
         grp_slot = prio_slot;
         if (grp_ok)
            for (int i = 0; i < DEPTH; i++)
               if (i >= run_start && i < prio_slot && same_dir[i]) grp_slot = i + 1;
      end
      assign pos = CNT_W'(grp_slot);
   end else begin : g_plain
      logic unused_grp;
      assign unused_grp = grp_ok ^ (^same_dir) ^ run_start[0];
      assign pos = CNT_W'(prio_slot);
   end
endmodule

// File: rtl/cq_shift.sv
module cq_shift #(
   parameter int DEPTH = 8,
   parameter int ENT_W = 22,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_go,
   input  logic             pop_go,
   input  logic [CNT_W-1:0] pos,
   input  logic [ENT_W-1:0] new_ent,
   output logic [ENT_W-1:0] slot [DEPTH],
   output logic [CNT_W-1:0] fill,
   output logic [DEPTH-1:0] live
);
   logic [ENT_W-1:0] ext [DEPTH+1];
   logic [ENT_W-1:0] ins [DEPTH+1];
   logic [ENT_W-1:0] nxt [DEPTH];
   logic [CNT_W-1:0] fill_nxt;

   always_comb begin
      for (int i = 0; i < DEPTH; i++) ext[i] = slot[i];
      ext[DEPTH] = '0;
      for (int i = 0; i <= DEPTH; i++) begin
         if (!push_go || i < int'(pos))   ins[i] = ext[i];
         else if (i == int'(pos))         ins[i] = new_ent;
         else                             ins[i] = ext[(i == 0) ? 0 : i - 1];
      end
      for (int i = 0; i < DEPTH; i++) nxt[i] = pop_go ? ins[i+1] : ins[i];
      fill_nxt = fill + CNT_W'(push_go) - CNT_W'(pop_go);
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_live
      assign live[i] = (CNT_W'(i) < fill);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill <= '0;
         for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
      end else begin
         fill <= fill_nxt;
         for (int i = 0; i < DEPTH; i++) slot[i] <= nxt[i];
      end
   end
endmodule

// File: rtl/cq_place_queue.sv
module cq_place_queue #(
   parameter int DEPTH       = 8,
   parameter int PRIO_W      = 2,
   parameter int SRC_W       = 3,
   parameter int ADDR_W      = 16,
   parameter bit GROUP_LOGIC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_group_en,
   input  logic [ADDR_W-1:0] cfg_line_mask,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              in_wr,
   input  logic [PRIO_W-1:0] in_prio,
   input  logic [SRC_W-1:0]  in_src,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic              in_wbuf_hit,
   input  logic              pop,
   output logic              head_valid,
   output logic              head_wr,
   output logic [PRIO_W-1:0] head_prio,
   output logic [SRC_W-1:0]  head_src,
   output logic [ADDR_W-1:0] head_addr
);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int ENT_W = 1 + PRIO_W + SRC_W + ADDR_W;

   if (DEPTH < 2 || DEPTH > cq_pkg::CQ_MAX_DEPTH) begin : g_bad_depth
      $error("cq_place_queue: DEPTH out of range");
   end
   if (PRIO_W < 1 || SRC_W < 1 || ADDR_W < 1) begin : g_bad_width
      $error("cq_place_queue: field widths must be positive");
   end

   logic [ENT_W-1:0] slot [DEPTH];
   logic [CNT_W-1:0] fill;
   logic [DEPTH-1:0] live, blk, same_dir, less_urgent, prio_diff;
   logic [CNT_W-1:0] ins_pos;
   logic             push_go, pop_go;

   assign in_ready   = (fill < CNT_W'(DEPTH));
   assign head_valid = (fill != '0);
   assign push_go    = in_valid && in_ready;
   assign pop_go     = pop && head_valid;

   cq_match #(.DEPTH(DEPTH), .PRIO_W(PRIO_W), .SRC_W(SRC_W), .ADDR_W(ADDR_W), .ENT_W(ENT_W)) u_match (
      .slot(slot), .new_wr(in_wr), .new_prio(in_prio), .new_src(in_src),
      .new_addr(in_addr), .line_mask(cfg_line_mask), .blk(blk),
      .same_dir(same_dir), .less_urgent(less_urgent), .prio_diff(prio_diff)
   );

   cq_pick #(.DEPTH(DEPTH), .GROUPING(GROUP_LOGIC), .CNT_W(CNT_W)) u_pick (
      .live(live), .blk(blk), .same_dir(same_dir), .less_urgent(less_urgent),
      .prio_diff(prio_diff), .fill(fill), .grp_ok(cfg_group_en && !in_wbuf_hit),
      .pos(ins_pos)
   );

   cq_shift #(.DEPTH(DEPTH), .ENT_W(ENT_W), .CNT_W(CNT_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .push_go(push_go), .pop_go(pop_go), .pos(ins_pos),
      .new_ent({in_wr, in_prio, in_src, in_addr}), .slot(slot), .fill(fill), .live(live)
   );

   assign head_addr = slot[0][ADDR_W-1:0];
   assign head_src  = slot[0][ADDR_W +: SRC_W];
   assign head_prio = slot[0][ADDR_W+SRC_W +: PRIO_W];
   assign head_wr   = slot[0][ENT_W-1];
endmodule

// File: rtl/cq_place_queue_chk.sv
module cq_place_queue_chk #(
   parameter int DEPTH  = 8,
   parameter int PRIO_W = 2,
   parameter int SRC_W  = 3,
   parameter int ADDR_W = 16,
   parameter int CNT_W  = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic [PRIO_W-1:0] in_prio,
   input logic [SRC_W-1:0]  in_src,
   input logic [ADDR_W-1:0] in_addr,
   input logic [ADDR_W-1:0] cfg_line_mask,
   input logic              pop,
   input logic              head_valid,
   input logic              head_wr,
   input logic [PRIO_W-1:0] head_prio,
   input logic [SRC_W-1:0]  head_src,
   input logic [ADDR_W-1:0] head_addr,
   input logic [CNT_W-1:0]  ins_pos,
   input logic [CNT_W-1:0]  fill
);
   logic take;
   assign take = in_valid && in_ready;

   AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> ins_pos <= fill);                                                      // R2
   AST_PRIO_NOT_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
      take && head_valid && (in_prio >= head_prio) |-> ins_pos != '0);                // R2
   AST_SRC_NOT_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
      take && head_valid && (in_src == head_src) |-> ins_pos != '0);                  // R3
   AST_ADDR_NOT_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
      take && head_valid && (((in_addr ^ head_addr) & cfg_line_mask) == '0)
      |-> ins_pos != '0);                                                             // R4
   AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      head_valid && !pop && !(take && ins_pos == '0)
      |=> head_valid && $stable(head_wr) && $stable(head_prio)
          && $stable(head_src) && $stable(head_addr));                                // R7
   AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready && !pop |=> !in_ready);                                               // R8
   AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !head_valid && !in_valid |=> !head_valid);                                      // R9
   AST_PUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      !head_valid && in_valid |=> head_valid);                                        // R9
endmodule

bind cq_place_queue cq_place_queue_chk #(
   .DEPTH(DEPTH), .PRIO_W(PRIO_W), .SRC_W(SRC_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .in_prio(in_prio), .in_src(in_src), .in_addr(in_addr), .cfg_line_mask(cfg_line_mask),
   .pop(pop), .head_valid(head_valid), .head_wr(head_wr), .head_prio(head_prio),
   .head_src(head_src), .head_addr(head_addr), .ins_pos(ins_pos), .fill(fill)
);

// File: tb/test_cq_place_queue.sv
module test_cq_place_queue;
   localparam int D = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_group_en = 1'b0;
   logic [15:0] cfg_line_mask = 16'hFFF8;
   logic in_valid = 1'b0, in_wr = 1'b0, in_wbuf_hit = 1'b0, pop = 1'b0;
   logic [1:0] in_prio = '0;
   logic [2:0] in_src = '0;
   logic [15:0] in_addr = '0;
   logic in_ready, head_valid, head_wr;
   logic [1:0] head_prio;
   logic [2:0] head_src;
   logic [15:0] head_addr;

   int compared = 0, mismatched = 0;
   bit done = 1'b0;
   int m_wr[D], m_pr[D], m_src[D], m_ad[D];
   int m_n = 0;

   always #10 clk = ~clk;

   cq_place_queue #(.DEPTH(D), .PRIO_W(2), .SRC_W(3), .ADDR_W(16)) i_cq_place_queue (
      .clk(clk), .rst_n(rst_n), .cfg_group_en(cfg_group_en), .cfg_line_mask(cfg_line_mask),
      .in_valid(in_valid), .in_ready(in_ready), .in_wr(in_wr), .in_prio(in_prio),
      .in_src(in_src), .in_addr(in_addr), .in_wbuf_hit(in_wbuf_hit), .pop(pop),
      .head_valid(head_valid), .head_wr(head_wr), .head_prio(head_prio),
      .head_src(head_src), .head_addr(head_addr)
   );

   function automatic int exp_pos(int w, int p, int s, int a, bit g);
      int bar = 0, ps, rs, gp;
      int msk = int'(cfg_line_mask);
      for (int i = 0; i < m_n; i++)
         if (m_src[i] == s || (m_ad[i] & msk) == (a & msk)) bar = i + 1;
      ps = m_n;
      for (int i = m_n - 1; i >= bar; i--) if (m_pr[i] > p) ps = i;
      rs = bar;
      for (int i = bar; i < ps; i++) if (m_pr[i] != p) rs = i + 1;
      gp = ps;
      if (g) for (int i = rs; i < ps; i++) if (m_wr[i] == w) gp = i + 1;
      return gp;
   endfunction

   task automatic model(bit v, int w, int p, int s, int a, bit wb, bit pp);
      bit do_pop = pp && m_n > 0;
      if (v && m_n < D) begin
         int k = exp_pos(w, p, s, a, cfg_group_en && !wb);
         for (int i = m_n; i > k; i--) begin
            m_wr[i] = m_wr[i-1]; m_pr[i] = m_pr[i-1]; m_src[i] = m_src[i-1]; m_ad[i] = m_ad[i-1];
         end
         m_wr[k] = w; m_pr[k] = p; m_src[k] = s; m_ad[k] = a;
         m_n++;
      end
      if (do_pop) begin
         for (int i = 0; i < m_n - 1; i++) begin
            m_wr[i] = m_wr[i+1]; m_pr[i] = m_pr[i+1]; m_src[i] = m_src[i+1]; m_ad[i] = m_ad[i+1];
         end
         m_n--;
      end
   endtask

   task automatic cmp(int act, int exp, string tag, string what);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic check_outs(string tag);
      cmp(int'(in_ready), int'(m_n < D), tag, "in_ready");
      cmp(int'(head_valid), int'(m_n > 0), tag, "head_valid");
      if (m_n > 0) begin
         cmp({int'(head_wr), int'(head_prio), int'(head_src), int'(head_addr)} == {m_wr[0], m_pr[0], m_src[0], m_ad[0]} ? 1 : 0,
             1, tag, "head entry matches model");
      end
   endtask

   task automatic step(bit v, int w, int p, int s, int a, bit wb, bit pp, string tag);
      in_valid = v; in_wr = w[0]; in_prio = 2'(p); in_src = 3'(s); in_addr = 16'(a);
      in_wbuf_hit = wb; pop = pp;
      model(v, w, p, s, a, wb, pp);
      @(negedge clk);
      in_valid = 1'b0; pop = 1'b0; in_wbuf_hit = 1'b0;
      check_outs(tag);
   endtask

   task automatic push(int w, int p, int s, int a, bit wb, string tag);
      step(1'b1, w, p, s, a, wb, 1'b0, tag);
   endtask

   task automatic drain_expect(int e0, int e1, int e2, bit by_src, string tag);
      int exp[3] = '{e0, e1, e2};
      for (int i = 0; i < 3; i++) begin
         cmp(by_src ? int'(head_src) : int'(head_wr), exp[i], tag, "drain order");
         step(1'b0, 0, 0, 0, 0, 1'b0, 1'b1, tag);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_outs("R1");

      // R2: more urgent command jumps ahead of a less urgent one
      push(0, 3, 1, 'h100, 0, "R2");
      push(0, 1, 2, 'h200, 0, "R2");
      cmp(int'(head_src), 2, "R2", "urgent first");
      step(0, 0, 0, 0, 0, 0, 1, "R2");
      step(0, 0, 0, 0, 0, 0, 1, "R2");

      // R5: grouping places second read behind first read
      cfg_group_en = 1'b1;
      push(0, 1, 1, 'h100, 0, "R5"); push(1, 1, 2, 'h200, 0, "R5"); push(0, 1, 3, 'h300, 0, "R5");
      drain_expect(1, 3, 2, 1, "R5");

      // R6: grouping off keeps arrival order
      cfg_group_en = 1'b0;
      push(0, 1, 1, 'h100, 0, "R6"); push(1, 1, 2, 'h200, 0, "R6"); push(0, 1, 3, 'h300, 0, "R6");
      drain_expect(1, 2, 3, 1, "R6");

      // R6: write-buffer conflict suppresses grouping
      cfg_group_en = 1'b1;
      push(0, 1, 1, 'h100, 0, "R6"); push(1, 1, 2, 'h200, 0, "R6"); push(0, 1, 3, 'h300, 1, "R6");
      drain_expect(1, 2, 3, 1, "R6");

      // R3: same source blocks grouping
      push(0, 1, 1, 'h100, 0, "R3"); push(1, 1, 2, 'h200, 0, "R3"); push(0, 1, 2, 'h400, 0, "R3");
      drain_expect(0, 1, 0, 0, "R3");

      // R4: line collision blocks grouping (0x204 vs 0x200 under mask FFF8)
      push(0, 1, 1, 'h100, 0, "R4"); push(1, 1, 2, 'h200, 0, "R4"); push(0, 1, 3, 'h204, 0, "R4");
      drain_expect(0, 1, 0, 0, "R4");

      // R8: fill, then an extra push is ignored; pop while full still works
      for (int i = 0; i < D; i++) push(i % 2, 2, i, 'h1000 + 16 * i, 0, "R8");
      cmp(int'(in_ready), 0, "R8", "full ready");
      push(1, 0, 7, 'h7000, 0, "R8");
      step(1, 0, 0, 6, 'h6000, 0, 1, "R8");

      // R7: drain all in order
      for (int i = 0; i < D + 1; i++) step(0, 0, 0, 0, 0, 0, 1, "R7");
      // R9: pop on empty ignored, push+pop on empty
      step(0, 0, 0, 0, 0, 0, 1, "R9");
      step(1, 1, 2, 5, 'h500, 0, 1, "R9");
      step(1, 0, 1, 4, 'h600, 0, 1, "R9");

      // Random mix checked against the model
      for (int n = 0; n < 4000; n++) begin
         if (n % 500 == 0) cfg_group_en = $urandom_range(0, 1) != 0;
         step($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 3),
              $urandom_range(0, 7), 'h100 * $urandom_range(1, 3) + 4 * $urandom_range(0, 3),
              $urandom_range(0, 7) == 0, $urandom_range(0, 2) == 0, "R7");
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule